// File: doc/BRIEF.md
# Stack-Relative Conditional Register Move Unit

This unit executes a family of eight conditional copy operations on an eight-entry floating-point register stack. Each entry holds an 80-bit value and a 2-bit tag. An operation is given as a two-byte opcode. The first byte picks a page: one page tests a flag condition as it is, the other tests its negation. The second byte picks one of four conditions and carries the stack-relative source index `i` in its low three bits.

When the chosen condition holds, the unit copies entry ST(i) into ST(0). Entries are addressed relative to a top-of-stack pointer supplied by the caller, and the pointer is never changed. The status flags are inputs only and are never modified.

Faults are checked before anything is written. A locked operation or a malformed opcode gives an invalid-opcode fault. Either of the two control bits gives a device-not-available fault.

An operation is issued with a one-cycle valid strobe. A completion pulse follows one cycle later, together with the fault and move indications. A load port fills entries by physical index, and a combinational read port returns any entry.

Top module: `cmov_unit`

## Requirements
- R1: With `op_hi` = 0xDA the condition is selected by `op_lo[4:3]`: 0 moves when CF=1, 1 when ZF=1, 2 when CF=1 or ZF=1, 3 when PF=1.
- R2: With `op_hi` = 0xDB the same `op_lo[4:3]` encodings select the negated tests: 0 moves when CF=0, 1 when ZF=0, 2 when CF=0 and ZF=0, 3 when PF=0.
- R3: The source is physical entry (`top_ptr` + `op_lo[2:0]`) mod 8 and the destination is physical entry `top_ptr`.
- R4: When the condition is false, `moved` stays 0 and the destination entry keeps its data and tag.
- R5: A move copies all 80 data bits and the 2-bit tag of the source into the destination.
- R6: With `cr_em` or `cr_ts` set and no invalid-opcode cause, `fault_nm` is raised and no entry changes.
- R7: With `lock_pfx` set, `fault_ud` is raised and no entry changes.
- R8: An `op_hi` other than 0xDA or 0xDB, or an `op_lo` outside 0xC0 to 0xDF, raises `fault_ud` and no entry changes.
- R9: When an invalid-opcode cause and a device-not-available cause are both present, only `fault_ud` is raised.
- R10: `done` is high in exactly the cycle after each cycle in which `issue_vld` is high, and operations may be issued back to back. `fault_ud`, `fault_nm` and `moved` are only ever high together with `done`.
- R11: A load writes data and tag to entry `load_idx`. If a load and a move target the same entry in the same cycle, the move's value is kept.
- R12: While reset is applied, `done`, `fault_ud`, `fault_nm` and `moved` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_vld | input | 1 | Issue strobe, one operation per high cycle |
| op_hi | input | 8 | First opcode byte (page select) |
| op_lo | input | 8 | Second opcode byte (condition and relative source) |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_pf | input | 1 | Parity flag |
| lock_pfx | input | 1 | Operation carries a lock prefix |
| cr_em | input | 1 | Emulation control bit |
| cr_ts | input | 1 | Task-switched control bit |
| top_ptr | input | 3 | Top-of-stack pointer |
| load_en | input | 1 | Load port write enable |
| load_idx | input | 3 | Load port physical index |
| load_data | input | 80 | Load port data |
| load_tag | input | 2 | Load port tag |
| rd_idx | input | 3 | Read port physical index |
| rd_data | output | 80 | Read port data |
| rd_tag | output | 2 | Read port tag |
| done | output | 1 | Completion pulse, one cycle after issue |
| fault_ud | output | 1 | Invalid-opcode fault, valid with done |
| fault_nm | output | 1 | Device-not-available fault, valid with done |
| moved | output | 1 | The copy was performed, valid with done |

## Verification
A wrong decode or wrong flag test shows up in the completion cycle: `moved` takes the wrong value, and reading the destination entry right afterwards shows a changed or stale value and tag. A wrong relative address shows as the wrong source value landing in entry `top_ptr`, or as a different entry changing. A wrong fault priority shows directly on `fault_ud` and `fault_nm` in the same pulse. Because every issue is followed one cycle later by a readback of the destination, a bad state is caught within two cycles of the faulty operation.

// File: rtl/cmov_pkg.sv
package cmov_pkg;

  typedef enum logic [1:0] {
    COND_CARRY        = 2'd0,
    COND_ZERO         = 2'd1,
    COND_CARRY_OR_ZERO = 2'd2,
    COND_PARITY       = 2'd3
  } cond_e;

  typedef struct packed {
    logic       illegal;
    logic       negate;
    cond_e      cond;
    logic [2:0] rel;
  } dec_t;

  typedef struct packed {
    logic cf;
    logic zf;
    logic pf;
  } flags_t;

  localparam logic [7:0] PAGE_POS   = 8'hDA;
  localparam logic [7:0] PAGE_NEG   = 8'hDB;
  localparam logic [2:0] ROW_PREFIX = 3'b110;

endpackage

// File: rtl/cmov_decode.sv
module cmov_decode
  import cmov_pkg::*;
(
  input  logic [7:0] op_hi,
  input  logic [7:0] op_lo,
  output dec_t       dec
);

  logic page_ok;
  logic row_ok;

  always_comb begin
    page_ok     = (op_hi == PAGE_POS) || (op_hi == PAGE_NEG);
    row_ok      = (op_lo[7:5] == ROW_PREFIX);
    dec.illegal = !(page_ok && row_ok);
    dec.negate  = (op_hi == PAGE_NEG);
    dec.cond    = cond_e'(op_lo[4:3]);
    dec.rel     = op_lo[2:0];
  end

endmodule

// File: rtl/cmov_cond.sv
module cmov_cond
  import cmov_pkg::*;
(
  input  cond_e  cond,
  input  logic   negate,
  input  flags_t flags,
  output logic   take
);

  logic raw;

  always_comb begin
    unique case (cond)
      COND_CARRY:         raw = flags.cf;
      COND_ZERO:          raw = flags.zf;
      COND_CARRY_OR_ZERO: raw = flags.cf | flags.zf;
      COND_PARITY:        raw = flags.pf;
      default:            raw = 1'b0;
    endcase
    take = raw ^ negate;
  end

endmodule

// File: rtl/cmov_regstack.sv
module cmov_regstack #(
  parameter int DATA_W = 80,
  parameter int TAG_W  = 2,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     load_en,
  input  logic [$clog2(DEPTH)-1:0] load_idx,
  input  logic [DATA_W-1:0]        load_data,
  input  logic [TAG_W-1:0]         load_tag,
  input  logic                     mv_en,
  input  logic [$clog2(DEPTH)-1:0] mv_dst,
  input  logic [$clog2(DEPTH)-1:0] mv_src,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_data,
  output logic [TAG_W-1:0]         rd_tag
);

  localparam int PTR_W  = $clog2(DEPTH);
  localparam int WORD_W = DATA_W + TAG_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] src_word;
  logic [WORD_W-1:0] load_word;

  always_comb begin
    src_word  = mem[mv_src];
    load_word = {load_tag, load_data};
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic              hit_mv;
    logic              hit_ld;
    logic              wen;
    logic [WORD_W-1:0] nxt;

    always_comb begin
      hit_mv = mv_en && (mv_dst == PTR_W'(e));
      hit_ld = load_en && (load_idx == PTR_W'(e));
      wen    = hit_mv || hit_ld;
      nxt    = hit_mv ? src_word : load_word;
    end

    always_ff @(posedge clk) begin
      if (wen) mem[e] <= nxt;
    end
  end

  always_comb begin
    {rd_tag, rd_data} = mem[rd_idx];
  end

endmodule

// File: rtl/cmov_unit.sv
module cmov_unit
  import cmov_pkg::*;
#(
  parameter int DATA_W = 80,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_vld,
  input  logic [7:0]        op_hi,
  input  logic [7:0]        op_lo,
  input  logic              flag_cf,
  input  logic              flag_zf,
  input  logic              flag_pf,
  input  logic              lock_pfx,
  input  logic              cr_em,
  input  logic              cr_ts,
  input  logic [2:0]        top_ptr,
  input  logic              load_en,
  input  logic [2:0]        load_idx,
  input  logic [DATA_W-1:0] load_data,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [2:0]        rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              done,
  output logic              fault_ud,
  output logic              fault_nm,
  output logic              moved
);

  localparam int REL_W = 3;
  localparam int DEPTH = 1 << REL_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  dec_t   dec;
  flags_t flags;
  logic   take;

  cmov_decode u_dec (
    .op_hi (op_hi),
    .op_lo (op_lo),
    .dec   (dec)
  );

  always_comb flags = '{cf: flag_cf, zf: flag_zf, pf: flag_pf};

  cmov_cond u_cond (
    .cond   (dec.cond),
    .negate (dec.negate),
    .flags  (flags),
    .take   (take)
  );

  // fault priority: invalid opcode over device not available
  logic             go;
  logic             ud_now;
  logic             nm_now;
  logic             mv_now;
  logic [REL_W-1:0] src_phys;

  always_comb begin
    go       = issue_vld && rst_q_n;
    ud_now   = dec.illegal || lock_pfx;
    nm_now   = !ud_now && (cr_em || cr_ts);
    mv_now   = go && !ud_now && !nm_now && take;
    src_phys = top_ptr + dec.rel;
  end

  cmov_regstack #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .DEPTH  (DEPTH)
  ) u_stack (
    .clk       (clk),
    .load_en   (load_en),
    .load_idx  (load_idx),
    .load_data (load_data),
    .load_tag  (load_tag),
    .mv_en     (mv_now),
    .mv_dst    (top_ptr),
    .mv_src    (src_phys),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .rd_tag    (rd_tag)
  );

  // completion status: next state then register
  logic done_d;
  logic ud_d;
  logic nm_d;
  logic mv_d;

  always_comb begin
    done_d = go;
    ud_d   = go && ud_now;
    nm_d   = go && nm_now;
    mv_d   = mv_now;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done     <= 1'b0;
      fault_ud <= 1'b0;
      fault_nm <= 1'b0;
      moved    <= 1'b0;
    end else begin
      done     <= done_d;
      fault_ud <= ud_d;
      fault_nm <= nm_d;
      moved    <= mv_d;
    end
  end

endmodule

// File: rtl/cmov_unit_chk.sv
module cmov_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic issue_vld,
  input logic lock_pfx,
  input logic done,
  input logic fault_ud,
  input logic fault_nm,
  input logic moved
);

  a_r10_done_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |=> done);

  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> !done);

  a_r10_status_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ud || fault_nm || moved) |-> done);

  a_r9_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_ud && fault_nm));

  a_r7_lock_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && lock_pfx) |=> (fault_ud && !moved));

  a_r6_nm_blocks_move: assert property (@(posedge clk) disable iff (!rst_n)
    fault_nm |-> !moved);

endmodule

bind cmov_unit cmov_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .issue_vld (issue_vld),
  .lock_pfx  (lock_pfx),
  .done      (done),
  .fault_ud  (fault_ud),
  .fault_nm  (fault_nm),
  .moved     (moved)
);

// File: tb/sim_cmov_unit.sv
`timescale 1ns/1ps
module sim_cmov_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_vld;
  logic [7:0]  op_hi, op_lo;
  logic        flag_cf, flag_zf, flag_pf;
  logic        lock_pfx, cr_em, cr_ts;
  logic [2:0]  top_ptr;
  logic        load_en;
  logic [2:0]  load_idx;
  logic [79:0] load_data;
  logic [1:0]  load_tag;
  logic [2:0]  rd_idx;
  logic [79:0] rd_data;
  logic [1:0]  rd_tag;
  logic        done, fault_ud, fault_nm, moved;

  always #2 clk = ~clk;

  cmov_unit u0 (.*);

  int checks = 0;
  int errors = 0;
  logic [81:0] model [8];
  logic [2:0]  exp_q [$];
  string       req_q [$];
  bit          finished = 0;

  function automatic logic [2:0] predict(logic [7:0] b0, logic [7:0] b1,
      logic cf, logic zf, logic pf, logic lk, logic em, logic ts);
    logic bad, c;
    bad = !(b0 == 8'hDA || b0 == 8'hDB) || (b1 < 8'hC0) || (b1 > 8'hDF);
    if (bad || lk) return 3'b100;
    if (em || ts)  return 3'b010;
    case (b1 & 8'hF8)
      8'hC0: c = cf;
      8'hC8: c = zf;
      8'hD0: c = cf | zf;
      default: c = pf;
    endcase
    if (b0 == 8'hDB) c = !c;
    return {2'b00, c};
  endfunction

  task automatic check(string req, logic [81:0] act, logic [81:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic issue(string req, logic [7:0] b0, logic [7:0] b1,
      logic cf, logic zf, logic pf, logic lk, logic em, logic ts, logic [2:0] tp);
    logic [2:0] e;
    e = predict(b0, b1, cf, zf, pf, lk, em, ts);
    op_hi = b0; op_lo = b1; flag_cf = cf; flag_zf = zf; flag_pf = pf;
    lock_pfx = lk; cr_em = em; cr_ts = ts; top_ptr = tp; issue_vld = 1'b1;
    exp_q.push_back(e);
    req_q.push_back(req);
    if (e[0]) model[tp] = model[3'(tp + b1[2:0])];
    @(posedge clk);
    @(negedge clk);
    issue_vld = 1'b0;
  endtask

  task automatic check_reg(string req, logic [2:0] idx);
    rd_idx = idx;
    #0.5;
    check(req, {rd_tag, rd_data}, model[idx]);
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < 8; k++) check_reg(req, 3'(k));
  endtask

  // monitor: compares completions against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 actual=done expected=idle");
      end else begin
        logic [2:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, {79'd0, fault_ud, fault_nm, moved}, {79'd0, e});
      end
    end else if (rst_n && (fault_ud || fault_nm || moved)) begin
      checks++; errors++;
      $display("FAIL R10 actual=%b expected=000", {fault_ud, fault_nm, moved});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; issue_vld = 0; op_hi = 0; op_lo = 0;
    flag_cf = 0; flag_zf = 0; flag_pf = 0; lock_pfx = 0; cr_em = 0; cr_ts = 0;
    top_ptr = 0; load_en = 0; load_idx = 0; load_data = 0; load_tag = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    // R12: status low under reset
    check("R12", {78'd0, done, fault_ud, fault_nm, moved}, 82'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: fill every entry through the load port
    for (int k = 0; k < 8; k++) begin
      load_en = 1; load_idx = 3'(k);
      load_data = {16'hA000 + 16'(k), 64'h0123_4567_89AB_CDEF ^ {8{8'(k * 17)}}};
      load_tag = 2'(k);
      model[k] = {load_tag, load_data};
      @(negedge clk);
    end
    load_en = 0;
    check_all("R11");

    // R1: positive page
    issue("R1", 8'hDA, 8'hC1, 1, 0, 0, 0, 0, 0, 3'd0); check_reg("R1 R5", 3'd0);
    issue("R4", 8'hDA, 8'hCA, 1, 0, 1, 0, 0, 0, 3'd0); check_reg("R4", 3'd0);
    issue("R1", 8'hDA, 8'hD3, 0, 1, 0, 0, 0, 0, 3'd0); check_reg("R1", 3'd0);
    issue("R1", 8'hDA, 8'hDC, 0, 0, 1, 0, 0, 0, 3'd0); check_reg("R1 R5", 3'd0);
    issue("R4", 8'hDA, 8'hD5, 0, 0, 1, 0, 0, 0, 3'd0); check_reg("R4", 3'd0);
    // R2: negated page
    issue("R2", 8'hDB, 8'hC6, 0, 1, 1, 0, 0, 0, 3'd1); check_reg("R2", 3'd1);
    issue("R4", 8'hDB, 8'hCB, 0, 1, 0, 0, 0, 0, 3'd1); check_reg("R4", 3'd1);
    issue("R2", 8'hDB, 8'hD4, 0, 0, 1, 0, 0, 0, 3'd2); check_reg("R2", 3'd2);
    issue("R4", 8'hDB, 8'hD1, 1, 0, 0, 0, 0, 0, 3'd2); check_reg("R4", 3'd2);
    issue("R4", 8'hDB, 8'hDD, 0, 0, 1, 0, 0, 0, 3'd2); check_reg("R4", 3'd2);
    // R3: relative addressing with wrap
    issue("R3", 8'hDB, 8'hC5, 0, 0, 0, 0, 0, 0, 3'd6); check_all("R3");
    issue("R3", 8'hDA, 8'hC7, 1, 0, 0, 0, 0, 0, 3'd7); check_all("R3");
    // R6, R7, R8, R9: faults leave the stack alone
    issue("R6", 8'hDA, 8'hC1, 1, 0, 0, 0, 1, 0, 3'd4); check_all("R6");
    issue("R6", 8'hDB, 8'hC2, 0, 0, 0, 0, 0, 1, 3'd4); check_all("R6");
    issue("R7", 8'hDA, 8'hC1, 1, 0, 0, 1, 0, 0, 3'd4); check_all("R7");
    issue("R8", 8'hDA, 8'hE1, 1, 0, 0, 0, 0, 0, 3'd4); check_all("R8");
    issue("R8", 8'hD9, 8'hC1, 1, 0, 0, 0, 0, 0, 3'd4); check_all("R8");
    issue("R8", 8'hDB, 8'hBF, 0, 0, 0, 0, 0, 0, 3'd4); check_all("R8");
    issue("R9", 8'hDA, 8'hC1, 1, 0, 0, 1, 1, 1, 3'd4); check_all("R9");
    issue("R9", 8'hDC, 8'hC1, 1, 0, 0, 0, 1, 0, 3'd4); check_all("R9");

    // R10: back-to-back issues
    issue("R10", 8'hDA, 8'hC1, 1, 0, 0, 0, 0, 0, 3'd3);
    issue("R10", 8'hDB, 8'hC2, 1, 0, 0, 0, 0, 0, 3'd3);
    issue("R10", 8'hDB, 8'hCB, 0, 0, 0, 0, 0, 0, 3'd5);
    repeat (2) @(negedge clk);
    check_all("R10");

    // R11: move and load hit the same entry together
    load_en = 1; load_idx = 3'd2; load_data = 80'hFFFF_EEEE_DDDD_CCCC_BBBB; load_tag = 2'd3;
    issue("R11", 8'hDA, 8'hC1, 1, 0, 0, 0, 0, 0, 3'd2);
    load_en = 0;
    check_all("R11");
    // R11: load alongside a move to another entry
    load_en = 1; load_idx = 3'd6; load_data = 80'h1234_5678_9ABC_DEF0_1357; load_tag = 2'd1;
    model[6] = {2'd1, 80'h1234_5678_9ABC_DEF0_1357};
    issue("R11", 8'hDA, 8'hC1, 1, 0, 0, 0, 0, 0, 3'd0);
    load_en = 0;
    check_all("R11");

    // mixed sweep over all conditions, pages and pointers
    for (int n = 0; n < 48; n++) begin
      logic [7:0] b1;
      b1 = 8'hC0 | 8'($urandom_range(0, 31));
      issue((b1[4:3] == 2'd0) ? "R1 R2" : "R3 R5",
            ($urandom_range(0, 1) != 0) ? 8'hDB : 8'hDA, b1,
            1'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'b0, 1'b0,
            3'($urandom));
      check_reg("R3", top_ptr);
    end
    check_all("R5");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 actual=%0d pending expected=0", exp_q.size());
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule